// File: doc/BRIEF.md
# Pulse-Gap Downlink Modulator

This block keys the carrier of a 125 kHz low-frequency reader to send one command from the reader to a tag. The field is normally on. Each symbol is a field-on interval whose length encodes the symbol value, followed by a short field-off gap. Durations are counted in carrier cycles, and a tick input pulses once per carrier cycle (8 µs).

A command begins on a start strobe. The block first holds the field on for a power-up interval so that the tag has energy. It then opens a start gap and emits the symbols. Four downlink encodings can be chosen. One carries two bits per symbol using four pulse lengths. Another sends a long reference pulse before the data.

Command bits come from an external producer through a two-bit look-ahead window. The block reports how many bits it consumed at each symbol boundary, and the producer shifts its stream by that amount. Any leading or reference zeros that a mode places in the bit stream are the producer's job; this block supplies only the timing.

Top module: `pulse_gap_modulator`

## Requirements
- R1: After a synchronous reset the field output is on (1), and busy and done are both low.
- R2: A start strobe seen while idle latches the mode and the bit count. The field then stays on for 625 ticks (power-up), followed by a start gap of 31 ticks with the field off. A count of zero ends the command after the start gap.
- R3: Every symbol is the field on for the symbol's duration, then the field off for a write gap of 20 ticks.
- R4: Mode 0 (fixed bit): a 0 bit is 18 ticks on and a 1 bit is 50 ticks on.
- R5: Mode 2 (leading zero): a 0 bit is 18 ticks on and a 1 bit is 40 ticks on.
- R6: Mode 3 (one of four): bits go two per symbol, with the first bit as the MSB. The pairs 00, 01, 10 and 11 give 18, 34, 50 and 66 ticks on.
- R7: Mode 1 (long reference): right after the start gap, a reference of 154 ticks on followed by a 20-tick gap is sent before the data. Data bits then use the fixed-bit timing.
- R8: `cmd_bits[1]` is the next bit to send and `cmd_bits[0]` is the bit after it. `take` gives the number of bits consumed (1, or 2 in mode 3) in the clock in which a symbol starts, and is 0 otherwise. In mode 3 an odd trailing bit is neither sent nor consumed.
- R9: All counters advance only on clocks where `tick` is high, so durations in ticks do not depend on the tick rate.
- R10: `done` is high for exactly one clock, one clock after the last write gap ends. During that clock the field is on, and busy drops on the next clock.
- R11: A start strobe while busy is ignored, including any change of mode.
- R12: A synchronous reset in the middle of a command forces the field on and returns the block to idle at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One pulse per carrier cycle |
| start | input | 1 | Command start strobe |
| mode | input | 2 | Downlink encoding: 0 fixed, 1 long reference, 2 leading zero, 3 one of four |
| cmd_len | input | LEN_W | Number of command bits |
| cmd_bits | input | 2 | Look-ahead window: [1] next bit, [0] the bit after it |
| take | output | 2 | Bits consumed this clock |
| field_on | output | 1 | Carrier enable |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-clock completion pulse |

## Verification
The bench records the field as run lengths counted in ticks and compares every run against timing computed independently from the requirements.

It targets the following corner cases, each paired with the failure it would expose:
- **Swapped pair order in mode 3.** A design that decodes the pair in the wrong order would produce 34-tick and 50-tick pulses in swapped positions.
- **Odd trailing bit in mode 3.** A design that sends it would add an extra symbol and consume one bit too many.
- **Misplaced reference pulse.** A design that drops the reference or puts it after the data would shift every run.
- **Slow tick.** Running at a slower tick rate catches counters that advance on the clock instead of the tick.
- **Start while busy, and reset mid-command.** A strobe during a command would restart or re-time the command if it were not ignored. A reset in the middle must leave the field on and the block idle.

// File: rtl/pulse_gap_modulator.sv
module pulse_gap_modulator #(
  parameter int CNT_W     = 10,
  parameter int LEN_W     = 7,
  parameter int PWR_TICKS = 625,
  parameter int T_SGAP    = 31,
  parameter int T_WGAP    = 20,
  parameter int T_ZERO    = 18,
  parameter int T_ONE_FIX = 50,
  parameter int T_ONE_LZ  = 40,
  parameter int T_Q01     = 34,
  parameter int T_Q10     = 50,
  parameter int T_Q11     = 66,
  parameter int T_REF_ADD = 136
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic [1:0]       mode,
  input  logic [LEN_W-1:0] cmd_len,
  input  logic [1:0]       cmd_bits,
  output logic [1:0]       take,
  output logic             field_on,
  output logic             busy,
  output logic             done
);
  localparam int T_REF = T_ZERO + T_REF_ADD;

  typedef enum logic [2:0] {IDLE, PWR, SGAP, REF, SYM, WGAP, FIN} st_t;

  st_t              st;
  logic [CNT_W-1:0] cnt, dur, sym_dur, new_dur;
  logic [1:0]       mode_q;
  logic [LEN_W-1:0] rem;
  logic             q4, llr, more, phase_end, next_sym;

  assign q4        = (mode_q == 2'd3);
  assign llr       = (mode_q == 2'd1);
  assign more      = q4 ? (rem >= LEN_W'(2)) : (rem != '0);
  assign phase_end = tick && (cnt == dur - CNT_W'(1));
  assign next_sym  = phase_end && ((st == SGAP && !llr) || st == WGAP);
  assign take      = (next_sym && more) ? (q4 ? 2'd2 : 2'd1) : 2'd0;

  assign field_on  = !(st == SGAP || st == WGAP);
  assign busy      = (st != IDLE);
  assign done      = (st == FIN);

  always_comb begin
    case (st)
      PWR:     dur = CNT_W'(PWR_TICKS);
      SGAP:    dur = CNT_W'(T_SGAP);
      REF:     dur = CNT_W'(T_REF);
      SYM:     dur = sym_dur;
      default: dur = CNT_W'(T_WGAP);
    endcase
  end

  always_comb begin
    if (q4) begin
      case (cmd_bits)
        2'b00:   new_dur = CNT_W'(T_ZERO);
        2'b01:   new_dur = CNT_W'(T_Q01);
        2'b10:   new_dur = CNT_W'(T_Q10);
        default: new_dur = CNT_W'(T_Q11);
      endcase
    end else if (cmd_bits[1]) begin
      new_dur = (mode_q == 2'd2) ? CNT_W'(T_ONE_LZ) : CNT_W'(T_ONE_FIX);
    end else begin
      new_dur = CNT_W'(T_ZERO);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= IDLE;
      cnt     <= '0;
      mode_q  <= 2'd0;
      rem     <= '0;
      sym_dur <= '0;
    end else begin
      case (st)
        IDLE: if (start) begin
          st     <= PWR;
          cnt    <= '0;
          mode_q <= mode;
          rem    <= cmd_len;
        end
        FIN: st <= IDLE;
        default: if (tick) begin
          if (phase_end) begin
            cnt <= '0;
            if (next_sym) begin
              if (more) begin
                st      <= SYM;
                sym_dur <= new_dur;
                rem     <= rem - LEN_W'(take);
              end else begin
                st <= FIN;
              end
            end else begin
              case (st)
                PWR:     st <= SGAP;
                SGAP:    st <= REF;
                default: st <= WGAP;
              endcase
            end
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/pulse_gap_modulator_chk.sv
module pulse_gap_modulator_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic [1:0] take,
  input logic       field_on,
  input logic       busy,
  input logic       done
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) rst |=> field_on && !busy && !done);

  // R12
  idle_field_chk: assert property (@(posedge clk) disable iff (rst) !busy |-> field_on);

  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (rst) start && !busy |=> busy);

  // R10
  done_release_chk: assert property (@(posedge clk) disable iff (rst) done |=> !busy && !done);

  // R10
  done_field_chk: assert property (@(posedge clk) disable iff (rst) done |-> field_on);

  // R11
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst) busy && !done |=> busy);

  // R8
  take_symbol_chk: assert property (@(posedge clk) disable iff (rst) take != 2'd0 |=> field_on && busy);

  // R8
  take_range_chk: assert property (@(posedge clk) disable iff (rst) take != 2'd3);
endmodule

bind pulse_gap_modulator pulse_gap_modulator_chk chk_i (
  .clk(clk), .rst(rst), .start(start), .take(take),
  .field_on(field_on), .busy(busy), .done(done)
);

// File: tb/pulse_gap_modulator_tb_top.sv
module pulse_gap_modulator_tb_top;
  logic       clk = 0, rst = 1, tick = 0, start = 0;
  logic [1:0] mode = 0;
  logic [6:0] cmd_len = 0;
  logic [1:0] cmd_bits, take;
  logic       field_on, busy, done;

  int n_chk = 0, n_fail = 0;
  logic [0:127] bits = '0;
  int bp = 0;
  logic bp_clr = 0;
  int tdiv = 1, tcnt = 0;
  logic rec = 0;
  logic run_lvl [0:255];
  int   run_len [0:255];
  int   nruns = 0;
  logic exp_lvl [0:255];
  int   exp_len [0:255];
  int   ne = 0;

  always #2.5 clk = ~clk;

  pulse_gap_modulator dut_i (
    .clk(clk), .rst(rst), .tick(tick), .start(start), .mode(mode),
    .cmd_len(cmd_len), .cmd_bits(cmd_bits), .take(take),
    .field_on(field_on), .busy(busy), .done(done)
  );

  assign cmd_bits = {bits[bp[6:0]], bits[bp[6:0] + 7'd1]};

  always @(posedge clk) begin
    if (bp_clr) bp <= 0;
    else if (take != 2'd0) bp <= bp + int'(take);
    if (tcnt >= tdiv - 1) begin tcnt <= 0; tick <= 1; end
    else begin tcnt <= tcnt + 1; tick <= 0; end
  end

  always @(negedge clk) begin
    if (rec && tick && nruns < 256) begin
      if (nruns == 0 || run_lvl[nruns-1] != field_on) begin
        run_lvl[nruns] = field_on;
        run_len[nruns] = 1;
        nruns++;
      end else begin
        run_len[nruns-1]++;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int sym_ticks(input logic [1:0] m, input logic b1, input logic b0);
    if (m == 2'd3) return (b1 ? (b0 ? 66 : 50) : (b0 ? 34 : 18));
    if (!b1) return 18;
    return (m == 2'd2) ? 40 : 50;
  endfunction

  task automatic push(input logic l, input int d);
    exp_lvl[ne] = l;
    exp_len[ne] = d;
    ne++;
  endtask

  task automatic run_cmd(input logic [1:0] m, input int n, input logic [0:127] pat,
                         input int div, input int poke_at, input string req);
    int step, used, cyc;
    string tag;
    bits = pat; tdiv = div;
    @(negedge clk); bp_clr = 1;
    @(negedge clk); bp_clr = 0;
    mode = m; cmd_len = 7'(n); start = 1;
    @(posedge clk); #1; start = 0; nruns = 0; rec = 1;
    ne = 0; push(1, 625); push(0, 31);
    if (m == 2'd1) begin push(1, 154); push(0, 20); end
    step = (m == 2'd3) ? 2 : 1;
    used = 0;
    for (int i = 0; i + step <= n; i += step) begin
      push(1, sym_ticks(m, pat[i], (m == 2'd3) ? pat[i+1] : 1'b0));
      push(0, 20);
      used += step;
    end
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
      if (cyc == poke_at) begin start = 1; mode = ~m; end
      if (cyc == poke_at + 1) start = 0;
    end
    rec = 0;
    chk(done === 1'b1, "R10 done seen", int'(done), 1);
    chk(field_on === 1'b1, "R10 field on at done", int'(field_on), 1);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, "R10 done one clock / busy released",
        int'({done, busy}), 0);
    chk(bp == used, {req, " R8 bits consumed"}, bp, used);
    chk(nruns >= ne, {req, " run count"}, nruns, ne);
    for (int k = 0; k < ne; k++) begin
      if (k < 2) tag = "R2";
      else if (m == 2'd1 && k < 4) tag = "R7";
      else if (exp_lvl[k] == 1'b0) tag = "R3";
      else tag = req;
      if (k < nruns)
        chk(run_lvl[k] == exp_lvl[k] && run_len[k] == exp_len[k],
            {tag, " run length (ticks)"}, run_len[k], exp_len[k]);
    end
  endtask

  task automatic t_reset;
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(field_on === 1'b1, "R1 field on after reset", int'(field_on), 1);
    chk(busy === 1'b0 && done === 1'b0, "R1 idle after reset", int'({busy, done}), 0);
  endtask

  task automatic t_reset_mid;
    bits = '0; tdiv = 1;
    mode = 2'd0; cmd_len = 7'd8; start = 1;
    @(negedge clk); start = 0;
    repeat (640) @(negedge clk);
    chk(field_on === 1'b0, "R12 inside start gap", int'(field_on), 0);
    rst = 1;
    @(negedge clk); rst = 0;
    chk(field_on === 1'b1 && busy === 1'b0, "R12 reset mid command",
        int'({field_on, busy}), 2);
    repeat (50) @(negedge clk);
    chk(field_on === 1'b1 && busy === 1'b0, "R12 stays idle", int'({field_on, busy}), 2);
  endtask

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    run_cmd(2'd0, 8, {8'b10110010, 120'd0}, 1, -1, "R4");
    run_cmd(2'd2, 6, {6'b011010, 122'd0}, 3, -1, "R5 R9");
    run_cmd(2'd3, 8, {8'b00011011, 120'd0}, 1, -1, "R6");
    run_cmd(2'd3, 5, {5'b10011, 123'd0}, 2, -1, "R6 R8");
    run_cmd(2'd1, 4, {4'b1001, 124'd0}, 1, -1, "R7");
    run_cmd(2'd0, 0, '0, 1, -1, "R2");
    run_cmd(2'd0, 6, {6'b110100, 122'd0}, 1, 700, "R11");
    t_reset_mid();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule